// File: doc/BRIEF.md
# Drive Motor Start Delay Timer

This block measures the settling wait between turning on a drive spindle motor and letting a read or write begin. Software programs a 4-bit delay factor and a timer-mode bit through two byte-wide configuration write ports. The delay length is the factor multiplied by a per-rate constant. A factor of zero means 128. The constant comes from an eight-entry parameter table indexed by the timer-mode bit and the current 2-bit data-rate code.

A one-cycle `start` pulse latches the product into a down-counter. The counter then steps once per base `tick`. When the count runs out, the block raises `done` for one cycle so that command processing can proceed. A fresh `start` while a count is running restarts the wait from the full length. Configuration changes made during a count apply only to the next `start`.

Top module: `spinup_delay_timer`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0, and `done` stays 0 until a `start` is given.
- R2: A cycle with `cfgWrEn` high stores `cfgData[3:0]` as the delay factor. `cfgData[7:4]` is ignored.
- R3: A cycle with `modeWrEn` high stores `modeData[7]` as the timer-mode bit. `modeData[6:0]` is ignored.
- R4: The delay in ticks is factor × K(mode, rate). The table index is {mode, rate}, and entry i sits at bits i*8 +: 8 of `CONST_TABLE`. The default values are: mode 0 gives rates 0..3 = 3, 5, 7, 9; mode 1 gives rates 0..3 = 2, 4, 6, 8.
- R5: A stored factor of 0 gives a delay of 128 × K(mode, rate).
- R6: The count advances only on clock edges where `tick` is high. `done` rises right after the edge that carries the N-th tick following the `start` edge.
- R7: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R8: `busy` is high in the cycle after a `start`. A `start` during a running count reloads the full delay, counted from that new `start`.
- R9: Changes to the factor, the mode bit or `rate` during a running count do not change that count's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the delay-factor byte |
| cfgData | input | 8 | Delay-factor byte; bits 3:0 are used |
| modeWrEn | input | 1 | Write strobe for the mode byte |
| modeData | input | 8 | Mode byte; bit 7 is the timer-mode bit |
| rate | input | 2 | Current data-rate code |
| tick | input | 1 | Base time tick enable |
| start | input | 1 | Motor-selected pulse; loads the delay |
| busy | output | 1 | Count in progress |
| done | output | 1 | One-cycle delay-expired strobe |

## Verification
The hardest conditions to reach are those where a new event lands in the middle of a running count. These are a retrigger after only part of the ticks have passed, and a change of rate, mode and factor while the latched product is still being consumed. The stimulus starts a count and supplies a known number of ticks that stays below the total. At that point it either pulses `start` again or rewrites every configuration input. It then counts the remaining ticks until `done` and compares the total against the length latched at the relevant `start`. A sparse tick pattern (one tick every third cycle) separates tick counting from cycle counting.

// File: rtl/spinup_delay_pkg.sv
package spinup_delay_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // latch factor x constant into counter
    logic dec;    // step counter down by one
  } delayStrobes_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_COUNT = 1'b1
  } delayState_t;

endpackage

// File: rtl/spinup_delay_datapath.sv
module spinup_delay_datapath
  import spinup_delay_pkg::*;
#(
  parameter int CONST_W = 8,
  parameter int RATE_W  = 2,
  parameter logic [(2 << RATE_W)*CONST_W-1:0] CONST_TABLE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgData,
  input  logic              modeWrEn,
  input  logic [7:0]        modeData,
  input  logic [RATE_W-1:0] rate,
  input  delayStrobes_t     strobes,
  output logic              lastTick
);

  localparam int FACTOR_W  = 4;
  localparam int EFF_W     = 8;               // holds 1..128
  localparam int CNT_W     = CONST_W + EFF_W;
  localparam int N_ENTRIES = 2 << RATE_W;
  localparam int IDX_W     = RATE_W + 1;

  logic [FACTOR_W-1:0] factorReg;
  logic                modeBit;
  logic [EFF_W-1:0]    effFactor;
  logic [CONST_W-1:0]  constArr [N_ENTRIES];
  logic [CONST_W-1:0]  constSel;
  logic [IDX_W-1:0]    tableIdx;
  logic [CNT_W-1:0]    product;
  logic [CNT_W-1:0]    countReg;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      factorReg <= '0;
      modeBit   <= 1'b0;
    end else begin
      if (cfgWrEn)  factorReg <= cfgData[FACTOR_W-1:0];
      if (modeWrEn) modeBit   <= modeData[7];
    end
  end

  // unpack constant table
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_const
    assign constArr[i] = CONST_TABLE[i*CONST_W +: CONST_W];
  end

  assign tableIdx  = {modeBit, rate};
  assign constSel  = constArr[tableIdx];
  assign effFactor = (factorReg == '0) ? EFF_W'(128) : EFF_W'(factorReg);
  assign product   = CNT_W'(effFactor) * CNT_W'(constSel);

  // down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg <= '0;
    end else if (strobes.load) begin
      countReg <= product;
    end else if (strobes.dec && countReg != '0) begin
      countReg <= countReg - CNT_W'(1);
    end
  end

  assign lastTick = (countReg <= CNT_W'(1));

endmodule

// File: rtl/spinup_delay_ctrl.sv
module spinup_delay_ctrl
  import spinup_delay_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          tick,
  input  logic          lastTick,
  output delayStrobes_t strobes,
  output logic          busy,
  output logic          done
);

  delayState_t state, stateNext;
  logic        expire;

  // a start always wins over a terminal tick in the same cycle
  assign expire = (state == ST_COUNT) && tick && lastTick && !start;

  always_comb begin
    strobes.load = start;
    strobes.dec  = (state == ST_COUNT) && tick && !start;
    stateNext    = state;
    if (start)       stateNext = ST_COUNT;
    else if (expire) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= expire;
    end
  end

  assign busy = (state == ST_COUNT);

endmodule

// File: rtl/spinup_delay_timer.sv
module spinup_delay_timer
  import spinup_delay_pkg::*;
#(
  parameter int CONST_W = 8,
  parameter int RATE_W  = 2,
  // entry {mode,rate}: mode0 = 3,5,7,9  mode1 = 2,4,6,8
  parameter logic [(2 << RATE_W)*CONST_W-1:0] CONST_TABLE =
    {8'd8, 8'd6, 8'd4, 8'd2, 8'd9, 8'd7, 8'd5, 8'd3}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgData,
  input  logic              modeWrEn,
  input  logic [7:0]        modeData,
  input  logic [RATE_W-1:0] rate,
  input  logic              tick,
  input  logic              start,
  output logic              busy,
  output logic              done
);

  delayStrobes_t strobes;
  logic          lastTick;

  spinup_delay_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .tick     (tick),
    .lastTick (lastTick),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  spinup_delay_datapath #(
    .CONST_W     (CONST_W),
    .RATE_W      (RATE_W),
    .CONST_TABLE (CONST_TABLE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgData  (cfgData),
    .modeWrEn (modeWrEn),
    .modeData (modeData),
    .rate     (rate),
    .strobes  (strobes),
    .lastTick (lastTick)
  );

endmodule

// File: rtl/spinup_delay_checker.sv
module spinup_delay_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic tick,
  input logic busy,
  input logic done
);

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!done && !busy); // R1
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R7

  AST_DONE_FROM_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy)); // R6

  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(tick)); // R6

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busy); // R8

endmodule

bind spinup_delay_timer spinup_delay_checker u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .tick  (tick),
  .busy  (busy),
  .done  (done)
);

// File: tb/spinup_delay_timer_tb.sv
module spinup_delay_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWrEn, modeWrEn, tick, start;
  logic [7:0] cfgData, modeData;
  logic [1:0] rate;
  logic       busy, done;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spinup_delay_timer u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgData(cfgData),
    .modeWrEn(modeWrEn), .modeData(modeData), .rate(rate),
    .tick(tick), .start(start), .busy(busy), .done(done)
  );

  function automatic int kOf(input int m, input int r);
    return (m != 0) ? (2 + 2*r) : (3 + 2*r);
  endfunction

  function automatic int expDelay(input int f, input int m, input int r);
    return ((f == 0) ? 128 : f) * kOf(m, r);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic writeMode(input logic [7:0] v);
    @(negedge clk); modeWrEn = 1'b1; modeData = v;
    @(negedge clk); modeWrEn = 1'b0;
  endtask

  task automatic startPulse(input string req);
    @(negedge clk); start = 1'b1; tick = 1'b0;
    @(posedge clk); #1;
    check(req, busy, 1);
    @(negedge clk); start = 1'b0;
  endtask

  // supply k ticks, done must stay low
  task automatic runTicks(input int k, input string req);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk); #1;
      check(req, done, 0);
    end
    @(negedge clk); tick = 1'b0;
  endtask

  // tick every 'period' cycles, count ticks until done
  task automatic waitDone(input int exp, input int period, input string req);
    int ticks = 0;
    bit got = 0;
    for (int cyc = 0; cyc < LIMIT && !got; cyc++) begin
      @(negedge clk); tick = ((cyc % period) == period - 1);
      @(posedge clk); #1;
      if (tick) ticks++;
      if (done) begin
        got = 1;
        check("R7 busy low with done", busy, 0);
      end
    end
    check(req, got ? ticks : -1, exp);
    @(negedge clk); tick = 1'b0;
    @(posedge clk); #1;
    check("R7 done single cycle", done, 0);
  endtask

  task automatic doReset();
    rstN = 1'b0; cfgWrEn = 0; modeWrEn = 0; tick = 0; start = 0;
    cfgData = '0; modeData = '0; rate = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic testIdleAfterReset();
    tick = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      check("R1 idle no done", done | busy, 0);
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic testBasic();
    writeCfg(8'h03); writeMode(8'h00); rate = 2'd1;
    startPulse("R8 busy after start");
    waitDone(expDelay(3, 0, 1), 1, "R4 basic factor3 rate1");
  endtask

  task automatic testSweep();
    writeCfg(8'h02);
    for (int m = 0; m < 2; m++) begin
      writeMode(m ? 8'h80 : 8'h00);
      for (int r = 0; r < 4; r++) begin
        rate = 2'(r);
        startPulse("R8 busy after start");
        waitDone(expDelay(2, m, r), 1, $sformatf("R4 sweep mode%0d rate%0d", m, r));
      end
    end
  endtask

  task automatic testZeroFactor();
    writeCfg(8'h00); writeMode(8'h80); rate = 2'd0;
    startPulse("R8 busy after start");
    waitDone(expDelay(0, 1, 0), 1, "R5 factor zero means 128");
  endtask

  task automatic testFieldMasks();
    writeCfg(8'hF2); writeMode(8'h7F); rate = 2'd3;
    startPulse("R8 busy after start");
    waitDone(expDelay(2, 0, 3), 1, "R2 R3 upper cfg bits and low mode bits ignored");
    writeMode(8'h80);
    startPulse("R8 busy after start");
    waitDone(expDelay(2, 1, 3), 1, "R3 mode bit7 selects group");
  endtask

  task automatic testSparseTick();
    writeCfg(8'h03); writeMode(8'h00); rate = 2'd1;
    startPulse("R8 busy after start");
    waitDone(expDelay(3, 0, 1), 3, "R6 counts ticks not cycles");
  endtask

  task automatic testRetrigger();
    writeCfg(8'h04); writeMode(8'h00); rate = 2'd2;
    startPulse("R8 busy after start");
    runTicks(10, "R8 no done before retrigger");
    startPulse("R8 busy after retrigger");
    waitDone(expDelay(4, 0, 2), 1, "R8 retrigger reloads full delay");
  endtask

  task automatic testMidChange();
    writeCfg(8'h05); writeMode(8'h00); rate = 2'd0;
    startPulse("R8 busy after start");
    runTicks(4, "R9 no early done");
    rate = 2'd3;
    writeCfg(8'h0F);
    writeMode(8'h80);
    waitDone(expDelay(5, 0, 0) - 4, 1, "R9 config change mid count ignored");
    startPulse("R8 busy after start");
    waitDone(expDelay(15, 1, 3), 1, "R9 new config used on next start");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    testIdleAfterReset();
    testBasic();
    testSweep();
    testZeroFactor();
    testFieldMasks();
    testSparseTick();
    testRetrigger();
    testMidChange();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule